// File: doc/BRIEF.md
# Four-in-a-row run detector

This block watches a single serial bit and raises a flag once that bit has kept the same value, either all ones or all zeros, across the four most recent rising clock edges. It is a Moore machine with nine states. One state is idle, four states count a run of zeros and four count a run of ones. The flag is decoded from the current state alone, so it changes only after a clock edge and never follows the input combinationally.

A run that continues past four samples keeps the flag raised on every further edge, so overlapping runs are reported. A sample of the opposite value restarts counting in the other chain at a length of one. The four-bit state code is also driven out for observation. Reset is synchronous and active-low.

Top module: `run4_detector`

## Requirements
- R1: When `rst_n` is low at a rising edge, the state code becomes 0 (idle) and `match_out` becomes 0, whatever the value of `bit_in`.
- R2: After a rising edge with `rst_n` high, `match_out` is 1 exactly when `bit_in` held one value at each of the last four rising edges since reset was released; otherwise it is 0.
- R3: A run that continues beyond four samples keeps `match_out` at 1 after every further edge of the same value (overlapping detection).
- R4: Starting from idle, after 1, 2, 3 and 4 or more consecutive zero samples the state code is 1, 2, 3 and 4, respectively.
- R5: Starting from idle, after 1, 2, 3 and 4 or more consecutive one samples the state code is 5, 6, 7 and 8, respectively.
- R6: From any state, a sample of value 0 that breaks a run of ones moves the state code to 1, and a sample of value 1 that breaks a run of zeros (or arrives in idle) moves it to 5.
- R7: `match_out` is 1 exactly when the state code is 4 or 8.
- R8: Reset is synchronous: lowering `rst_n` between edges leaves `state_code` and `match_out` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial sample observed on each rising edge |
| match_out | output | 1 | High when the last four samples are equal |
| state_code | output | 4 | Current binary state code (0 idle, 1-4 zero run, 5-8 one run) |

## Verification
In the same edge, the block can break one run and start the next, or sustain a detection and take a reset. Random stimulus that keeps the previous bit three times out of four produces many runs that end exactly at, or just past, four samples. Occasional resets land in the middle of those runs. Every edge is judged against a run-length counter in the bench, which gives both the expected state code and the expected flag. Directed sequences add a reset that is lowered between edges, and a reversal straight out of a held detection.

// File: rtl/run4_pkg.sv
// Shared types for the four-in-a-row run detector.
// Assumes a binary state encoding whose codes are observed outside the block.
package run4_pkg;

    localparam int STATE_W = 4;

    // Binary codes are fixed; the zero chain and the one chain are each contiguous.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 4'd0,
        ST_ZERO1 = 4'd1,
        ST_ZERO2 = 4'd2,
        ST_ZERO3 = 4'd3,
        ST_ZERO4 = 4'd4,
        ST_ONE1  = 4'd5,
        ST_ONE2  = 4'd6,
        ST_ONE3  = 4'd7,
        ST_ONE4  = 4'd8
    } run_state_e;

endpackage

// File: rtl/run4_next_state.sv
// Next-state table for the run detector.
// Assumes the current state may hold any 4-bit value; unused codes recover to idle.
module run4_next_state
    import run4_pkg::*;
(
    input  run_state_e cur_state,
    input  logic       sample,
    output run_state_e nxt_state
);

    // Purpose: pick the successor state from the current state and the sample.
    always_comb begin
        unique case (cur_state)
            ST_IDLE:  nxt_state = sample ? ST_ONE1 : ST_ZERO1;
            ST_ZERO1: nxt_state = sample ? ST_ONE1 : ST_ZERO2;
            ST_ZERO2: nxt_state = sample ? ST_ONE1 : ST_ZERO3;
            ST_ZERO3: nxt_state = sample ? ST_ONE1 : ST_ZERO4;
            ST_ZERO4: nxt_state = sample ? ST_ONE1 : ST_ZERO4;
            ST_ONE1:  nxt_state = sample ? ST_ONE2 : ST_ZERO1;
            ST_ONE2:  nxt_state = sample ? ST_ONE3 : ST_ZERO1;
            ST_ONE3:  nxt_state = sample ? ST_ONE4 : ST_ZERO1;
            ST_ONE4:  nxt_state = sample ? ST_ONE4 : ST_ZERO1;
            default:  nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/run4_state_reg.sv
// State register with a synchronous active-low reset to a parameter value.
// Assumes a single clock domain; reset is sampled only on the rising edge.
module run4_state_reg #(
    parameter int                WIDTH     = 4,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Purpose: hold the state; load the reset value when rst_n is low at an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

endmodule

// File: rtl/run4_output_decode.sv
// Moore output decode: the flag depends on the current state only.
// Assumes the terminal states of both chains are the only detecting states.
module run4_output_decode
    import run4_pkg::*;
(
    input  run_state_e cur_state,
    output logic       detect
);

    // Purpose: raise the flag in the last state of either chain.
    always_comb begin
        case (cur_state)
            ST_ZERO4, ST_ONE4: detect = 1'b1;
            default:           detect = 1'b0;
        endcase
    end

endmodule

// File: rtl/run4_detector.sv
// Top of the four-in-a-row run detector: next-state table, state register
// and output decode wired together. Assumes bit_in is synchronous to clk.
module run4_detector
    import run4_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_in,
    output logic               match_out,
    output logic [STATE_W-1:0] state_code
);

    logic [STATE_W-1:0] state_q;
    run_state_e         cur_state;
    run_state_e         nxt_state;

    assign cur_state  = run_state_e'(state_q);
    assign state_code = state_q;

    run4_next_state u_next (
        .cur_state (cur_state),
        .sample    (bit_in),
        .nxt_state (nxt_state)
    );

    run4_state_reg #(
        .WIDTH     (STATE_W),
        .RESET_VAL (ST_IDLE)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_state),
        .q     (state_q)
    );

    run4_output_decode u_dec (
        .cur_state (cur_state),
        .detect    (match_out)
    );

endmodule

// File: rtl/run4_detector_checker.sv
// Property checker for run4_detector, bound to every instance of the top.
// Assumes it observes only the top-level ports.
module run4_detector_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       match_out,
    input logic [3:0] state_code
);

    // R1: a low reset at an edge returns to idle.
    a_r1_reset_to_idle: assert property (@(posedge clk)
        !rst_n |=> (state_code == 4'd0 && !match_out));

    // R2: a raised flag means the last four samples agreed.
    a_r2_run_of_four: assert property (@(posedge clk) disable iff (!rst_n)
        match_out |-> ($past(bit_in, 1) == $past(bit_in, 2) &&
                       $past(bit_in, 2) == $past(bit_in, 3) &&
                       $past(bit_in, 3) == $past(bit_in, 4)));

    // R3: a continued run keeps the flag high.
    a_r3_overlap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (match_out && state_code == 4'd4 && !bit_in) |=> match_out);

    // R6: a one breaks a zero run into the first one state.
    a_r6_break_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code <= 4'd4 && bit_in) |=> state_code == 4'd5);

    // R6: a zero breaks a one run into the first zero state.
    a_r6_break_one_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code >= 4'd5 && state_code <= 4'd8 && !bit_in) |=> state_code == 4'd1);

    // R7: the flag appears only in the two terminal states.
    a_r7_flag_states: assert property (@(posedge clk) disable iff (!rst_n)
        match_out |-> (state_code == 4'd4 || state_code == 4'd8));

endmodule

bind run4_detector run4_detector_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_in     (bit_in),
    .match_out  (match_out),
    .state_code (state_code)
);

// File: tb/run4_detector_bench.sv
// Self-checking bench: a run-length model predicts the state code and the flag.
module run4_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       match_out;
    logic [3:0] state_code;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  run_len  = 0;
    logic last_bit = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    run4_detector u_run4_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .match_out  (match_out),
        .state_code (state_code)
    );

    // Expected state code from the model run length and polarity (R4, R5).
    function automatic logic [3:0] exp_code(input int len, input logic pol);
        if (len == 0) return 4'd0;
        return pol ? 4'(4 + len) : 4'(len);
    endfunction

    // Expected flag: four equal samples in a row (R2, R7).
    function automatic logic exp_flag(input int len);
        return len >= 4;
    endfunction

    task automatic check(input string tag);
        logic [3:0] es;
        logic       ez;
        es = exp_code(run_len, last_bit);
        ez = exp_flag(run_len);
        n_checks++;
        if (state_code !== es) begin
            n_fails++;
            $display("FAIL %s state_code actual=%0d expected=%0d", tag, state_code, es);
        end
        n_checks++;
        if (match_out !== ez) begin
            n_fails++;
            $display("FAIL %s match_out actual=%0b expected=%0b", tag, match_out, ez);
        end
    endtask

    // Drive one edge's inputs, advance the model, then check just after the edge.
    task automatic step(input logic w, input logic rn, input string tag);
        @(negedge clk);
        bit_in = w;
        rst_n  = rn;
        @(posedge clk);
        if (!rn) run_len = 0;
        else if (run_len > 0 && w == last_bit) run_len = (run_len < 4) ? run_len + 1 : 4;
        else run_len = 1;
        if (rn) last_bit = w;
        #1;
        check(tag);
    endtask

    initial begin
        logic w;
        // R1: reset with either input value.
        step(1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, "R1");
        // R4: zero chain, then overlap R3.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R4");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R3");
        // R6: reversal straight out of a detection, then R5 one chain.
        step(1'b1, 1'b1, "R6");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, "R6");
        step(1'b1, 1'b1, "R6");
        // R2: three equal samples are not enough.
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, "R2");
        step(1'b0, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");
        // R8: reset lowered between edges has no effect until the edge.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R8");
        @(posedge clk);
        run_len = 0;
        #1;
        check("R1");
        // Random runs with occasional resets (R2).
        void'($urandom(32'd20240611));
        w = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(3, 0) == 0) w = ~w;
            step(w, ($urandom_range(63, 0) != 0), "R2");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule